// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock that is driven to an SD card from one of three base clocks. The base clocks reach the block as single-cycle strobes in the system clock domain, one strobe for every edge (rising or falling) of the base clock. A two-bit select picks the base clock. A 16-bit control register sets three things: an even divider, an internal clock enable and a separate enable for the card clock output. The register also reports when the internal clock has settled.

Software brings the clock up in a fixed order. It first sets the internal enable together with the divider value, then waits for the settled flag, and only then sets the output enable. The divider field N holds half of the wanted divisor, so the card clock runs at the base frequency divided by 2·N. A value of zero passes the base clock through undivided.

The output comes from a single register and is gated only while it is low. Changes to the divider or to the source are taken up at the start of the next output period. Because of this, no high phase is ever cut short.

Top module: `sdclk_ctrl`

## Requirements
- R1: The control register maps as follows. Bits 15:8 hold the divider field N. Bit 0 is the internal enable and bit 2 is the card output enable; both read back as written. Bit 1 is the read-only settled flag, and writes to it are ignored. All other bits read 0.
- R2: After reset the register reads 0x0000 and `card_clk` is low.
- R3: After a write sets the internal enable, the settled flag reads 1 from the cycle of the 32nd strobe of the selected source counted after that write, and reads 0 before it.
- R4: A write that clears the internal enable makes the settled flag read 0 in the cycle right after the write.
- R5: `base_sel` picks the source. 00 and 01 pick `bus_tick`, 10 picks `pll_tick` and 11 picks `xtal_tick`. The settle count and the divider use only the selected strobe, and a change of selection while the clock runs is taken up at the next rising edge of the divided clock.
- R6: Each low phase of the running card clock spans H strobes of the selected source, where H = 1 for N = 0 and H = 2·N otherwise.
- R7: `card_clk` stays low unless the internal enable, the settled flag and the output enable are all set.
- R8: Every high phase of `card_clk` spans exactly H strobes. This also holds when the output enable or the internal enable is cleared during that phase. `card_clk` changes level only on a strobe.
- R9: A new N written during a period leaves that period unchanged and takes effect from the next rising edge of the divided clock.
- R10: Writing 0x0000 stops the clock. After the current high phase, if any, ends, `card_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | Edge strobe of the bus base clock |
| pll_tick | input | 1 | Edge strobe of the PLL base clock |
| xtal_tick | input | 1 | Edge strobe of the crystal base clock |
| base_sel | input | 2 | Base clock select |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write data |
| ctrl_rdata | output | 16 | Control register read value |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
The three strobe inputs are driven at independent random densities, so a block that counts the wrong source produces phase lengths that do not match the expected ones. A case in which only the unselected sources toggle shows that the settle count follows the selected source. Divider values of 0, 1, small random values and 255 separate the undivided case from the 2·N rule. Writes of N and of the source select during a low phase show whether a change lands immediately or only at the period start. Clearing the output enable or the internal enable while the clock is high shows whether a high phase gets cut short.

// File: rtl/sdclk_pkg.sv
// Package sdclk_pkg: control register bit positions and base-source codes
// shared by the card clock generator and its submodules.
package sdclk_pkg;

    // Control register layout (16 bits)
    localparam int CC_EN_BIT     = 0;   // internal clock enable
    localparam int CC_STABLE_BIT = 1;   // settled flag, read-only
    localparam int CC_OUT_BIT    = 2;   // card clock output enable
    localparam int CC_DIV_LSB    = 8;   // divider field, half of divisor

    // Base clock selection codes
    typedef enum logic [1:0] {
        SRC_BUS_A = 2'b00,
        SRC_BUS_B = 2'b01,
        SRC_PLL   = 2'b10,
        SRC_XTAL  = 2'b11
    } base_src_e;

endpackage

// File: rtl/sdclk_src_mux.sv
// Module sdclk_src_mux: picks the edge strobe of the selected base clock.
// Assumes each strobe is a one-cycle pulse per base-clock edge, already in
// the clk domain. Purely combinational.
module sdclk_src_mux
    import sdclk_pkg::*;
(
    input  base_src_e sel,
    input  logic      bus_tick,
    input  logic      pll_tick,
    input  logic      xtal_tick,
    output logic      tick
);

    // Route the strobe of the chosen source
    always_comb begin
        case (sel)
            SRC_PLL:  tick = pll_tick;
            SRC_XTAL: tick = xtal_tick;
            default:  tick = bus_tick;
        endcase
    end

endmodule

// File: rtl/sdclk_settle.sv
// Module sdclk_settle: raises a settled flag once SETTLE_EDGES strobes of the
// active source have passed with the internal enable set. The flag is masked
// by the enable so that it drops at once when the enable is cleared.
// Assumes SETTLE_EDGES >= 1.
module sdclk_settle #(
    parameter int SETTLE_EDGES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic stable
);

    localparam int CW = $clog2(SETTLE_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_EDGES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Count selected strobes while enabled, restart when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!en) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end
        end
    end

    // Masked flag: low in the same cycle the enable is removed
    assign stable = done_q & en;

endmodule

// File: rtl/sdclk_divider.sv
// Module sdclk_divider: even divider on the active strobe. Each half period
// lasts 1 strobe for a zero field, 2*N strobes otherwise. The divider field
// and the source select are taken in only at the start of a period (rising
// edge of the divided level) or while idle. Once started, the divider keeps
// running until its level is low, so a high phase always completes.
module sdclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_field,
    input  logic [1:0]       sel_field,
    output logic             level_q,
    output logic             level_next,
    output logic [DIV_W-1:0] div_act,
    output logic [1:0]       sel_act
);

    localparam int HW = DIV_W + 1;

    logic [HW-1:0] cnt_q;
    logic [HW-1:0] half_m1;
    logic          running;
    logic          wrap;

    // Last count of a half period for the active divider value
    always_comb begin
        if (div_act == '0) begin
            half_m1 = '0;
        end else begin
            half_m1 = {div_act, 1'b0} - HW'(1);
        end
    end

    assign running = run_req | level_q;
    assign wrap    = tick && (cnt_q == half_m1);

    // Level the divided clock takes at the coming edge
    always_comb begin
        if (!running) begin
            level_next = 1'b0;
        end else if (wrap) begin
            level_next = ~level_q;
        end else begin
            level_next = level_q;
        end
    end

    // Half-period counter, level toggle and period-start configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
            div_act <= '0;
            sel_act <= '0;
        end else if (!running) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
            div_act <= div_field;
            sel_act <= sel_field;
        end else if (tick) begin
            if (wrap) begin
                cnt_q   <= '0;
                level_q <= ~level_q;
                if (!level_q) begin
                    div_act <= div_field;
                    sel_act <= sel_field;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdclk_out_gate.sv
// Module sdclk_out_gate: gates the divided level onto the card clock pin
// from one register. The gate only follows its request while the divided
// level is and stays low, so a pulse is never started or ended early.
module sdclk_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic level_next,
    output logic card_clk
);

    logic gate_q;
    logic card_q;

    // Gate follows the request only during the low phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (!level_next) begin
            gate_q <= want;
        end
    end

    // Single output register: divided level ANDed with the held gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_q <= 1'b0;
        end else begin
            card_q <= level_next & gate_q;
        end
    end

    assign card_clk = card_q;

endmodule

// File: rtl/sdclk_ctrl.sv
// Module sdclk_ctrl: SD card clock generator top. It holds the 16-bit control
// register and connects source select, settle detection, the even divider
// and the output gate. Assumes DIV_W <= 8 so that the field fits bits 15:8,
// and assumes base clocks arrive as per-edge strobes synchronous to clk.
module sdclk_ctrl
    import sdclk_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int SETTLE_EDGES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_tick,
    input  logic        pll_tick,
    input  logic        xtal_tick,
    input  logic [1:0]  base_sel,
    input  logic        ctrl_wr,
    input  logic [15:0] ctrl_wdata,
    output logic [15:0] ctrl_rdata,
    output logic        card_clk
);

    logic [DIV_W-1:0] div_q;
    logic             out_en_q;
    logic             ien_q;
    logic             stable_w;
    logic             src_tick;
    logic             div_level;
    logic             div_level_next;
    logic [DIV_W-1:0] div_act;
    logic [1:0]       sel_act;
    logic             gate_want;

    // Control register write; the settled bit is not storable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            out_en_q <= 1'b0;
            ien_q    <= 1'b0;
        end else if (ctrl_wr) begin
            div_q    <= ctrl_wdata[CC_DIV_LSB +: DIV_W];
            out_en_q <= ctrl_wdata[CC_OUT_BIT];
            ien_q    <= ctrl_wdata[CC_EN_BIT];
        end
    end

    // Read value assembly, unused bits zero
    always_comb begin
        ctrl_rdata                       = '0;
        ctrl_rdata[CC_DIV_LSB +: DIV_W]  = div_q;
        ctrl_rdata[CC_OUT_BIT]           = out_en_q;
        ctrl_rdata[CC_STABLE_BIT]        = stable_w;
        ctrl_rdata[CC_EN_BIT]            = ien_q;
    end

    sdclk_src_mux u_mux (
        .sel       (base_src_e'(sel_act)),
        .bus_tick  (bus_tick),
        .pll_tick  (pll_tick),
        .xtal_tick (xtal_tick),
        .tick      (src_tick)
    );

    sdclk_settle #(
        .SETTLE_EDGES (SETTLE_EDGES)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ien_q),
        .tick   (src_tick),
        .stable (stable_w)
    );

    sdclk_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_req    (ien_q),
        .tick       (src_tick),
        .div_field  (div_q),
        .sel_field  (base_sel),
        .level_q    (div_level),
        .level_next (div_level_next),
        .div_act    (div_act),
        .sel_act    (sel_act)
    );

    assign gate_want = ien_q & stable_w & out_en_q;

    sdclk_out_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (gate_want),
        .level_next (div_level_next),
        .card_clk   (card_clk)
    );

endmodule

// File: rtl/sdclk_ctrl_chk.sv
// Module sdclk_ctrl_chk: temporal checks on the card clock generator,
// attached to every sdclk_ctrl instance by the bind below.
module sdclk_ctrl_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ien,
    input logic             out_en,
    input logic             stable,
    input logic             card_clk,
    input logic             src_tick,
    input logic             div_level,
    input logic [DIV_W-1:0] div_act,
    input logic [1:0]       sel_act
);

    // R7: a rising card edge needs all three conditions two samples before
    assert_card_rise_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(ien && stable && out_en, 2));

    // R8: the card clock rises only with a strobe of the active source
    assert_card_rise_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(src_tick));

    // R8: the card clock falls only with a strobe, never from gating
    assert_card_fall_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk) |-> $past(src_tick));

    // R9: the active divider value moves only while the divided level is low
    assert_div_latch_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> !$past(div_level));

    // R5: the active source moves only while the divided level is low
    assert_sel_latch_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_act) |-> !$past(div_level));

    // R3: the settled flag can only rise with the enable already set
    assert_stable_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(ien));

endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien       (ien_q),
    .out_en    (out_en_q),
    .stable    (stable_w),
    .card_clk  (card_clk),
    .src_tick  (src_tick),
    .div_level (div_level),
    .div_act   (div_act),
    .sel_act   (sel_act)
);

// File: tb/tb_sdclk_ctrl.sv
module tb_sdclk_ctrl;

    localparam int SETTLE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic        pll_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic [1:0]  base_sel = 2'b00;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = 16'h0000;
    logic [15:0] ctrl_rdata;
    logic        card_clk;

    int checks = 0;
    int errors = 0;
    int prob_b = 0;
    int prob_p = 0;
    int prob_x = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdclk_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_tick   (bus_tick),
        .pll_tick   (pll_tick),
        .xtal_tick  (xtal_tick),
        .base_sel   (base_sel),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .card_clk   (card_clk)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int half_len(input int n);
        return (n == 0) ? 1 : 2 * n;
    endfunction

    function automatic bit pick(input logic [1:0] s, input bit b, input bit p, input bit x);
        case (s)
            2'b10:   return p;
            2'b11:   return x;
            default: return b;
        endcase
    endfunction

    // Random strobes at per-source densities
    always @(negedge clk) begin
        bus_tick  = (int'($urandom_range(99)) < prob_b);
        pll_tick  = (int'($urandom_range(99)) < prob_p);
        xtal_tick = (int'($urandom_range(99)) < prob_x);
    end

    // Input snapshot at each active edge
    bit          tb_cap, tp_cap, tx_cap, cfg_evt;
    logic [1:0]  sel_cap;
    logic [15:0] rd_prev = 16'h0000;
    always @(posedge clk) begin
        tb_cap  = bus_tick;
        tp_cap  = pll_tick;
        tx_cap  = xtal_tick;
        sel_cap = base_sel;
        cfg_evt = ctrl_wr && ((ctrl_wdata[0] != rd_prev[0]) || (ctrl_wdata[2] != rd_prev[2]));
    end

    // Phase monitor: R6 low phases, R8 high phases, R5/R9 via period-start latch
    int         hi_cnt = 0, lo_cnt = 0, act_n = 0, edges = 0, hi_done = 0;
    bit         hi_valid = 1'b0, lo_valid = 1'b0, card_prev = 1'b0;
    logic [1:0] act_sel = 2'b00;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit t = pick(act_sel, tb_cap, tp_cap, tx_cap);
            if (cfg_evt) lo_valid = 1'b0;
            if (card_clk && !card_prev) begin
                edges++;
                lo_cnt += int'(t);
                if (lo_valid)
                    check(lo_cnt == half_len(act_n), "R6", "low phase strobes", lo_cnt, half_len(act_n));
                act_n    = int'(rd_prev[15:8]);
                act_sel  = sel_cap;
                hi_cnt   = 0;
                hi_valid = 1'b1;
            end else if (!card_clk && card_prev) begin
                edges++;
                hi_cnt += int'(t);
                if (hi_valid) begin
                    check(hi_cnt == half_len(act_n), "R8", "high phase strobes", hi_cnt, half_len(act_n));
                    hi_done++;
                end
                lo_cnt   = 0;
                lo_valid = !cfg_evt;
            end else if (card_clk) begin
                hi_cnt += int'(t);
            end else begin
                lo_cnt += int'(t);
            end
        end
        rd_prev   = ctrl_rdata;
        card_prev = card_clk;
    end

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic wait_stable();
        for (int i = 0; i < 5000 && !ctrl_rdata[1]; i++) @(negedge clk);
    endtask

    task automatic wait_edges(input int k);
        automatic int e0 = edges;
        for (int i = 0; i < 20000 && (edges - e0) < k; i++) @(negedge clk);
    endtask

    task automatic wait_level(input bit v);
        for (int i = 0; i < 5000 && card_clk != v; i++) @(negedge clk);
    endtask

    // R3/R5: settled flag tracks strobes of the selected source only
    task automatic settle_test(input logic [1:0] s);
        automatic int cnt = 0;
        wr(16'h0000);
        base_sel = s;
        wr(16'h0101);
        for (int i = 0; i < 5000 && cnt < SETTLE + 2; i++) begin
            @(negedge clk);
            cnt += int'(pick(s, tb_cap, tp_cap, tx_cap));
            check(ctrl_rdata[1] == (cnt >= SETTLE), "R3", "settled flag vs strobe count",
                  ctrl_rdata[1], (cnt >= SETTLE));
        end
    endtask

    // R10: after stop, the clock ends low and stays low
    task automatic stop_check();
        automatic int bad = 0;
        wr(16'h0000);
        check(ctrl_rdata == 16'h0000, "R10", "register after stop", ctrl_rdata, 0);
        repeat (400) @(negedge clk);
        repeat (60) begin
            @(negedge clk);
            if (card_clk) bad++;
        end
        check(bad == 0, "R10", "high samples after stop", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctrl_rdata == 16'h0000, "R2", "register after reset", ctrl_rdata, 0);
        check(card_clk == 1'b0, "R2", "card clock after reset", card_clk, 0);

        // R1: field map, read-only bit 1, zero bits
        wr(16'hFFFF);
        check(ctrl_rdata == 16'hFF05, "R1", "all-ones write", ctrl_rdata, 16'hFF05);
        wr(16'h5A01);
        check(ctrl_rdata == 16'h5A01, "R1", "pattern write", ctrl_rdata, 16'h5A01);
        wr(16'h0000);
        check(ctrl_rdata == 16'h0000, "R1", "zero write", ctrl_rdata, 0);

        // R5: PLL selected but silent while the bus strobes run
        prob_b = 100; prob_p = 0; prob_x = 0;
        base_sel = 2'b10;
        wr(16'h0105);
        repeat (100) @(negedge clk);
        check(ctrl_rdata[1] == 1'b0, "R5", "settled with silent source", ctrl_rdata[1], 0);
        check(card_clk == 1'b0, "R7", "card clock before settle", card_clk, 0);

        prob_b = 70; prob_p = 50; prob_x = 30;
        settle_test(2'b10);
        settle_test(2'b00);
        settle_test(2'b01);
        settle_test(2'b11);

        // R4: clearing the enable drops the flag at once
        wr(16'h0100);
        check(ctrl_rdata[1] == 1'b0, "R4", "settled after enable clear", ctrl_rdata[1], 0);
        check(ctrl_rdata == 16'h0100, "R4", "register after enable clear", ctrl_rdata, 16'h0100);

        // R7: enables together, card clock must wait for settled
        begin
            automatic bit early = 1'b0;
            prob_b = 60; base_sel = 2'b00;
            wr(16'h0205);
            for (int i = 0; i < 5000 && !ctrl_rdata[1]; i++) begin
                if (card_clk) early = 1'b1;
                @(negedge clk);
            end
            check(early == 1'b0, "R7", "high before settled", early, 0);
            wait_edges(6);
            wr(16'h0201);
            repeat (100) @(negedge clk);
            early = 1'b0;
            repeat (100) begin
                @(negedge clk);
                if (card_clk) early = 1'b1;
            end
            check(early == 1'b0, "R7", "high with output disabled", early, 0);
            stop_check();
        end

        // Random runs across sources, divider values and mid-run changes
        for (int it = 0; it < 24; it++) begin
            automatic int r = $urandom_range(9);
            automatic int n = (r < 3) ? r : $urandom_range(12);
            automatic int act = $urandom_range(3);
            prob_b = $urandom_range(100, 30);
            prob_p = $urandom_range(100, 30);
            prob_x = $urandom_range(100, 30);
            base_sel = 2'($urandom_range(3));
            wr(16'((n << 8) | 1));
            wait_stable();
            wr(16'((n << 8) | 5));
            wait_edges(6);
            case (act)
                0: begin   // R9: new divider value in the middle of a low phase
                    wait_level(1'b0);
                    wr(16'(($urandom_range(12) << 8) | 5));
                    wait_edges(6);
                end
                1: begin   // R8: output enable cleared while high
                    wait_level(1'b1);
                    wr(16'((n << 8) | 1));
                    wait_edges(1);
                end
                2: begin   // R8/R4: internal enable cleared while high
                    wait_level(1'b1);
                    wr(16'((n << 8) | 4));
                    check(ctrl_rdata[1] == 1'b0, "R4", "settled after clear in run", ctrl_rdata[1], 0);
                    wait_edges(1);
                end
                default: begin   // R5: source changed while running
                    base_sel = 2'($urandom_range(3));
                    wait_edges(6);
                end
            endcase
            stop_check();
        end

        // R6/R8: widest divider and the undivided case at full strobe rate
        prob_b = 100; base_sel = 2'b00;
        wr(16'hFF01);
        wait_stable();
        wr(16'hFF05);
        wait_edges(4);
        stop_check();
        wr(16'h0001);
        wait_stable();
        wr(16'h0005);
        wait_edges(10);
        stop_check();

        check(hi_done >= 20, "R8", "high phases measured", hi_done, 20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule